// File: doc/BRIEF.md
# T1 Framing-Bit Error Injector

This block sits in the transmit path of a T1 framer, between the frame assembler and the line side. It receives the serial frame stream one bit per bit-enable strobe, together with a mark on the first bit of each superframe or multiframe. It follows the bit and frame position from that mark and, on request, inverts chosen framing-pattern bits so that the synchronizer at the far end can be tested. All other bits pass straight through in the same cycle.

Two controls act independently. The continuous control inverts one framing-pattern bit out of every 128 for as long as it stays high. The burst control inverts the next three framing-pattern bits after each rising edge, which is enough to knock the far end out of frame lock. A mode input selects superframe (12 frames) or extended superframe (24 frames) numbering. That choice decides which F bits may be touched: the terminal framing bits in superframe mode, or the pattern-sequence bits in extended mode.

Top module: `t1FbitInjector`

## Requirements
- R1: `dataOut` equals `dataIn` in the same cycle whenever `bitEn` is low or the current bit is not an eligible framing bit. There is no added latency.
- R2: With `esfMode` = 0, only bit 0 of frames 1, 3, 5, 7, 9 and 11 is eligible. Frames are counted from 1 at the frame whose bit 0 carries `multiframeStart`, and a superframe holds 12 frames of `FRAME_BITS` bits.
- R3: With `esfMode` = 1, only bit 0 of frames 4, 8, 12, 16, 20 and 24 of a 24-frame multiframe is eligible.
- R4: While `contEn` is high, the eligible bits are counted starting at zero. The 128th eligible bit (`CONT_PERIOD`) is inverted, and so is every 128th one after it.
- R5: A cycle with `contEn` low clears the continuous count, so after re-enabling, the first inversion again falls on the `CONT_PERIOD`-th eligible bit.
- R6: A rising edge of `burstEn` (high in a cycle after a low cycle) inverts the next `BURST_LEN` (3) eligible bits that follow the edge cycle, and then inverts nothing more.
- R7: Holding `burstEn` high does not re-arm the burst. Only a new rising edge does, and a new edge restarts the count of three.
- R8: When a burst inversion and a continuous inversion fall on the same bit, the bit is inverted once, and both counts advance as usual.
- R9: A change of `esfMode` clears both the burst count and the continuous count.
- R10: After reset, no bit is inverted until the first `multiframeStart` has been seen together with `bitEn`.
- R11: A `multiframeStart` with `bitEn` re-aligns the position to bit 0 of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | A stream bit is present this cycle |
| multiframeStart | input | 1 | This bit is bit 0 of frame 1 |
| esfMode | input | 1 | 0 = 12-frame superframe, 1 = 24-frame multiframe |
| contEn | input | 1 | Continuous 1-in-128 corruption control |
| burstEn | input | 1 | Burst control; a rising edge arms a 3-bit burst |
| dataIn | input | 1 | Serial bit to transmit |
| dataOut | output | 1 | Serial bit after optional inversion |

## Verification
`dataOut` is a combinational function of `dataIn` and registered state, so each bit's result is due in the same cycle the bit is presented. The bench drives every input at the falling edge and samples one time unit later, before the next rising edge. Control edges, mode changes and `multiframeStart` change the registered counts at the following rising edge, so they first affect the bits of the next cycle. The bench's reference model advances its own counts at that point. Window checks compare inversion totals against the number of eligible bits divided by the period, and against the fixed burst length.

// File: rtl/t1InjPkg.sv
package t1InjPkg;
  typedef struct packed {
    logic eligible;
    logic burstHit;
    logic contHit;
  } injStrobe_t;
endpackage

// File: rtl/injFrameTrack.sv
module injFrameTrack #(
  parameter int FRAME_BITS = 193
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic multiframeStart,
  input  logic esfMode,
  output logic eligible
);
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int D4_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int FRM_W      = $clog2(ESF_FRAMES);

  logic [BIT_W-1:0] bitCnt, curBit;
  logic [FRM_W-1:0] frameCnt, curFrame, lastFrame;
  logic alignNow, locked, ftSlot, fpsSlot;

  always_comb begin
    alignNow  = bitEn && multiframeStart;
    curBit    = alignNow ? '0 : bitCnt;
    curFrame  = alignNow ? '0 : frameCnt;
    lastFrame = esfMode ? FRM_W'(ESF_FRAMES - 1) : FRM_W'(D4_FRAMES - 1);
    // zero-based even frames carry terminal framing bits (R2)
    ftSlot    = ~curFrame[0];
    // zero-based frames 3,7,..,23 carry pattern-sequence bits (R3)
    fpsSlot   = (curFrame[1:0] == 2'b11);
    eligible  = bitEn && (locked || alignNow) && (curBit == '0) &&
                (esfMode ? fpsSlot : ftSlot);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      frameCnt <= '0;
      locked   <= 1'b0;
    end else if (bitEn) begin
      if (alignNow) locked <= 1'b1;
      if (curBit == BIT_W'(FRAME_BITS - 1)) begin
        bitCnt   <= '0;
        frameCnt <= (curFrame >= lastFrame) ? '0 : curFrame + 1'b1;
      end else begin
        bitCnt   <= curBit + 1'b1;
        frameCnt <= curFrame;
      end
    end
  end
endmodule

// File: rtl/injCtrl.sv
module injCtrl
  import t1InjPkg::*;
#(
  parameter int CONT_PERIOD = 128,
  parameter int BURST_LEN   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic eligible,
  input  logic esfMode,
  input  logic contEn,
  input  logic burstEn,
  output injStrobe_t strobes,
  output logic [$clog2(CONT_PERIOD)-1:0] contCnt,
  output logic [$clog2(BURST_LEN+1)-1:0] burstLeft
);
  localparam int CNT_W = $clog2(CONT_PERIOD);
  localparam int BL_W  = $clog2(BURST_LEN + 1);

  logic burstPrev, modePrev, burstRise, modeChange;

  always_comb begin
    burstRise        = burstEn && !burstPrev;
    modeChange       = esfMode != modePrev;
    strobes.eligible = eligible;
    strobes.burstHit = eligible && (burstLeft != '0);
    strobes.contHit  = eligible && contEn && (contCnt == CNT_W'(CONT_PERIOD - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstPrev <= 1'b0;
      modePrev  <= 1'b0;
      burstLeft <= '0;
      contCnt   <= '0;
    end else begin
      burstPrev <= burstEn;
      modePrev  <= esfMode;
      if (modeChange) begin
        burstLeft <= '0;
        contCnt   <= '0;
      end else begin
        if (burstRise)             burstLeft <= BL_W'(BURST_LEN);
        else if (strobes.burstHit) burstLeft <= burstLeft - 1'b1;
        if (!contEn)               contCnt <= '0;
        else if (eligible)         contCnt <= strobes.contHit ? '0 : contCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/injDatapath.sv
module injDatapath
  import t1InjPkg::*;
(
  input  logic       dataIn,
  input  injStrobe_t strobes,
  output logic       dataOut
);
  logic flip;
  always_comb begin
    // OR, not XOR: a coinciding burst and continuous hit invert once (R8)
    flip    = strobes.eligible && (strobes.burstHit || strobes.contHit);
    dataOut = dataIn ^ flip;
  end
endmodule

// File: rtl/t1FbitInjector.sv
module t1FbitInjector
  import t1InjPkg::*;
#(
  parameter int FRAME_BITS  = 193,
  parameter int CONT_PERIOD = 128,
  parameter int BURST_LEN   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic multiframeStart,
  input  logic esfMode,
  input  logic contEn,
  input  logic burstEn,
  input  logic dataIn,
  output logic dataOut
);
  logic eligible;
  injStrobe_t strobes;
  logic [$clog2(CONT_PERIOD)-1:0] contCnt;
  logic [$clog2(BURST_LEN+1)-1:0] burstLeft;

  injFrameTrack #(.FRAME_BITS(FRAME_BITS)) i_track (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .multiframeStart(multiframeStart),
    .esfMode(esfMode), .eligible(eligible)
  );

  injCtrl #(.CONT_PERIOD(CONT_PERIOD), .BURST_LEN(BURST_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .esfMode(esfMode),
    .contEn(contEn), .burstEn(burstEn), .strobes(strobes),
    .contCnt(contCnt), .burstLeft(burstLeft)
  );

  injDatapath i_dp (.dataIn(dataIn), .strobes(strobes), .dataOut(dataOut));
endmodule

// File: rtl/injChecker.sv
module injChecker #(
  parameter int CONT_PERIOD = 128,
  parameter int BURST_LEN   = 3
) (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic esfMode,
  input logic contEn,
  input logic burstEn,
  input logic dataIn,
  input logic dataOut,
  input logic eligible,
  input logic [$clog2(CONT_PERIOD)-1:0] contCnt,
  input logic [$clog2(BURST_LEN+1)-1:0] burstLeft
);
  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |-> dataOut == dataIn);

  // R2 / R3: only eligible framing bits may differ
  assert_only_eligible_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != dataIn) |-> eligible);

  assert_cont_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && contEn && !eligible && esfMode == $past(esfMode)) |=> $stable(contCnt));

  assert_cont_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !contEn |=> contCnt == '0);

  assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    burstLeft <= ($clog2(BURST_LEN+1))'(BURST_LEN));

  assert_no_rearm_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && burstEn && $past(burstEn) && !eligible && esfMode == $past(esfMode))
      |=> $stable(burstLeft));

  assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && esfMode != $past(esfMode)) |=> (contCnt == '0 && burstLeft == '0));
endmodule

bind t1FbitInjector injChecker #(.CONT_PERIOD(CONT_PERIOD), .BURST_LEN(BURST_LEN)) i_chk (.*);

// File: tb/test_t1FbitInjector.sv
module test_t1FbitInjector;
  localparam int CLK_PERIOD = 10;
  localparam int FB = 8;
  localparam int CP = 8;
  localparam int BL = 3;

  logic clk = 1'b0, rstN = 1'b0, bitEn = 1'b0, multiframeStart = 1'b0;
  logic esfMode = 1'b0, contEn = 1'b0, burstEn = 1'b0, dataIn = 1'b0;
  logic dataOut;

  t1FbitInjector #(.FRAME_BITS(FB), .CONT_PERIOD(CP), .BURST_LEN(BL)) i_t1FbitInjector (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .multiframeStart(multiframeStart),
    .esfMode(esfMode), .contEn(contEn), .burstEn(burstEn),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  // bench-side configuration, applied at the next falling edge
  bit cfgEsf = 0, cfgCont = 0, cfgBurst = 0, alignOn = 0;
  // reference model state
  int posBit = 0, posFrame = 0, cyc = 0, contM = 0, burstM = 0;
  bit lockM = 0, modePrevM = 0, burstPrevM = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string tag, inout int elig, inout int flips);
    bit e, bh, ch, rise, mchg;
    logic expOut;
    @(negedge clk);
    esfMode = cfgEsf; contEn = cfgCont; burstEn = cfgBurst;
    bitEn = (cyc % 5) != 4;
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dataIn = lfsr[0];
    multiframeStart = bitEn && alignOn && posBit == 0 && posFrame == 0;
    e  = bitEn && (lockM || multiframeStart) && posBit == 0 &&
         (cfgEsf ? (posFrame % 4 == 3) : (posFrame % 2 == 0));
    bh = e && burstM != 0;
    ch = e && cfgCont && contM == CP - 1;
    expOut = dataIn ^ (bh | ch);
    #1;
    chk(dataOut === expOut, tag, int'(dataOut), int'(expOut));
    if (e) elig++;
    if (dataOut !== dataIn) flips++;
    // model advance at the coming rising edge
    if (multiframeStart) lockM = 1;
    rise = cfgBurst && !burstPrevM;
    mchg = cfgEsf != modePrevM;
    burstPrevM = cfgBurst;
    modePrevM = cfgEsf;
    if (mchg) begin
      burstM = 0; contM = 0;
    end else begin
      if (rise) burstM = BL; else if (bh) burstM--;
      if (!cfgCont) contM = 0; else if (e) contM = ch ? 0 : contM + 1;
    end
    if (bitEn) begin
      if (posBit == FB - 1) begin
        posBit = 0;
        posFrame = (posFrame >= (cfgEsf ? 23 : 11)) ? 0 : posFrame + 1;
      end else posBit++;
    end
  endtask

  task automatic run(int n, string tag, output int elig, output int flips);
    elig = 0; flips = 0;
    repeat (n) step(tag, elig, flips);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int el, fl, e2, f2;
    // reset state: pass-through while in reset (R1)
    repeat (3) @(negedge clk);
    dataIn = 1'b1; bitEn = 1'b1;
    #1 chk(dataOut === 1'b1, "R1 reset pass-through", int'(dataOut), 1);
    @(negedge clk); rstN = 1'b1; bitEn = 1'b0;

    // R10: no corruption before alignment even with controls active
    cfgCont = 1; cfgBurst = 1;
    run(300, "R10", el, fl);
    chk(fl == 0, "R10 unaligned flips", fl, 0);
    cfgCont = 0; cfgBurst = 0;
    run(4, "R1", el, fl);

    // R11 / R2: align and run continuous in superframe mode
    alignOn = 1;
    run(130, "R11", el, fl);
    cfgCont = 1;
    run(2500, "R2", el, fl);
    chk(fl == el / CP, "R4 superframe flips per eligible", fl, el / CP);
    chk(el > 2 * CP, "R2 eligible bits seen", el, 2 * CP);

    // R5: drop and re-enable restarts the period
    cfgCont = 0; run(7, "R5", el, fl);
    cfgCont = 1; run(1900, "R5", el, fl);
    chk(fl == el / CP, "R5 restart flips per eligible", fl, el / CP);

    // R6 / R7: burst held high, then a second edge
    cfgCont = 0; run(3, "R6", el, fl);
    cfgBurst = 1; run(600, "R6", el, fl);
    chk(fl == BL, "R6 burst length", fl, BL);
    run(400, "R7", el, fl);
    chk(fl == 0, "R7 no re-arm while held", fl, 0);
    cfgBurst = 0; run(2, "R7", el, fl);
    cfgBurst = 1; run(600, "R7", el, fl);
    chk(fl == BL, "R7 second edge re-arms", fl, BL);
    cfgBurst = 0; run(2, "R7", el, fl);

    // R8: burst overlapping a continuous hit inverts once
    cfgCont = 1;
    el = 0; fl = 0;
    while (contM != CP - 3) step("R8", el, fl);
    cfgBurst = 1;
    el = 0; fl = 0;
    step("R8", el, fl);
    while (burstM != 0) step("R8", el, fl);
    chk(fl == BL, "R8 overlap single inversion", fl, BL);
    chk(contM == 0, "R8 continuous count advanced", contM, 0);
    run(1000, "R8", el, fl);

    // R3 / R9: switch to extended multiframe mid-count
    cfgBurst = 0; run(2, "R9", el, fl);
    el = 0; fl = 0;
    while (contM != 3) step("R9", el, fl);
    cfgEsf = 1; run(1, "R9", el, fl);
    run(4000, "R3", el, fl);
    chk(fl == el / CP, "R9 count cleared by mode change", fl, el / CP);
    chk(el > CP, "R3 eligible bits seen", el, CP);

    // R9: mode change cancels the rest of a burst
    cfgCont = 0; run(2, "R9", el, fl);
    cfgBurst = 1;
    el = 0; fl = 0;
    while (burstM != BL - 1) step("R9", el, fl);
    cfgEsf = 0; run(1, "R9", e2, f2);
    run(500, "R9", e2, f2);
    chk(f2 == 0, "R9 burst cleared by mode change", f2, 0);

    // R1: continuous plus burst in superframe mode, wide sweep
    cfgBurst = 0; cfgCont = 1;
    for (int k = 0; k < 6; k++) begin
      cfgBurst = ~cfgBurst;
      run(300 + 37 * k, "R1", el, fl);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule